// File: doc/BRIEF.md
# Complementary Phase Output Stage with Dead-Time Gating

This block drives one leg of a three-phase inverter. It has two pins, a high-side pin and a low-side pin. Both are active low: a pin at 0 switches its device on, and a pin at 1 leaves it off. Each pin takes its level from its own two-slot pattern register. The modulation timer fills both registers with a preload strobe and rotates them with an end-of-pulse strobe, so each pin alternates between its two programmed levels for as long as rotations keep arriving.

Each rotation starts a dead-time countdown of programmable length. A pin whose new level is 0 stays at 1 until the countdown has expired. A pin whose new level is 1 goes to 1 on the next clock, without waiting. The delay therefore falls only on the edge that switches a device on. As a result, two complementary patterns cannot turn both devices on at the same time.

A triangle-mode input locks the pattern registers against reloads, so that only rotations reach them. After reset, and until the first accepted preload, both pins stay at 1.

Top module: `cphase_out`

## Requirements
- R1: After reset, both pins are 1. They stay 1, whatever the strobes do, until the first accepted preload.
- R2: A preload is accepted when `loadStb` is high while `triMode` is 0. It stores `patHi[0]`/`patLo[0]` in slot 0 and `patHi[1]`/`patLo[1]` in slot 1. One clock after the load edge, the pins show the slot-0 bits. A pattern bit of 1 means the pin is at 1 (off), and 0 means the pin is at 0 (on).
- R3: `pulseEndStb` rotates each register: slot 0 takes the old slot 1, and slot 1 takes the old slot 0. Repeated rotations alternate the pins without end.
- R4: A pin whose new slot-0 bit is 1 changes to 1 one clock after the rotation edge, for any dead-time value.
- R5: A pin whose new slot-0 bit is 0 changes to 0 `deadCount`+1 clocks after the rotation edge. A `deadCount` of 0 gives one clock.
- R6: A rotation that arrives while a dead-time countdown is running restarts the countdown from the current `deadCount`.
- R7: While `triMode` is 1, `loadStb` is ignored and the registers only rotate.
- R8: If an accepted preload and a rotation arrive on the same clock, the preload wins and no rotation happens. An accepted preload also cancels any running dead-time countdown.
- R9: With complementary patterns (`patLo` = ~`patHi`), the two pins are never 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| patHi | input | 2 | High-side pattern; bit n goes to slot n |
| patLo | input | 2 | Low-side pattern; bit n goes to slot n |
| loadStb | input | 1 | Preload strobe, one clock wide |
| pulseEndStb | input | 1 | End-of-pulse strobe from the timer; rotates the patterns |
| deadCount | input | 8 | Dead-time length in clocks |
| triMode | input | 1 | Triangle mode; blocks preloads |
| phaseHiN | output | 1 | High-side pin, active low |
| phaseLoN | output | 1 | Low-side pin, active low |

## Verification
A wrong slot value or a wrong rotation reaches the pins one clock after the edge that stored it. It shows up as a pin swapped or not swapped against the pattern. A dead-time counter that was loaded wrongly, not restarted, or not cleared shows only on falling edges: the pin goes to 0 early or late, by the counting error in clocks. Rising edges never hide such a counter fault, and they never reveal it either. A missed arming, or a preload taken in triangle mode, shows as pins that stay at 1 when they should move, or that take up patterns that were never accepted.

// File: rtl/cphase_out_pkg.sv
package cphase_out_pkg;

  localparam int NUM_CHAN = 2;
  localparam int CH_HIGH  = 0;
  localparam int CH_LOW   = 1;

  typedef struct packed {
    logic takeLoad;
    logic takeShift;
    logic deadBusy;
    logic armed;
  } phaseStb_t;

endpackage

// File: rtl/cphase_ctrl.sv
module cphase_ctrl
  import cphase_out_pkg::*;
#(
  parameter int DEAD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic              pulseEndStb,
  input  logic              triMode,
  input  logic [DEAD_W-1:0] deadCount,
  output phaseStb_t         stb
);

  logic [DEAD_W-1:0] deadCnt;
  logic              armedQ;
  logic              loadOk;
  logic              shiftOk;

  // A preload is refused in triangle mode and wins over a rotation on the same clock.
  assign loadOk  = loadStb & ~triMode;
  assign shiftOk = pulseEndStb & ~loadOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      deadCnt <= '0;
    end else if (loadOk) begin
      deadCnt <= '0;
    end else if (shiftOk) begin
      deadCnt <= deadCount;
    end else if (deadCnt != '0) begin
      deadCnt <= deadCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
    end else if (loadOk) begin
      armedQ <= 1'b1;
    end
  end

  always_comb begin
    stb.takeLoad  = loadOk;
    stb.takeShift = shiftOk;
    stb.deadBusy  = (deadCnt != '0);
    stb.armed     = armedQ;
  end

endmodule

// File: rtl/cphase_gate.sv
module cphase_gate (
  input  logic clk,
  input  logic rstN,
  input  logic armed,
  input  logic headBit,
  input  logic deadBusy,
  output logic pinN
);

  // A rise to the off level is immediate; a fall to the on level waits out the dead time.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinN <= 1'b1;
    end else if (!armed) begin
      pinN <= 1'b1;
    end else if (headBit) begin
      pinN <= 1'b1;
    end else if (!deadBusy) begin
      pinN <= 1'b0;
    end
  end

endmodule

// File: rtl/cphase_dpath.sv
module cphase_dpath
  import cphase_out_pkg::*;
#(
  parameter int PAT_DEPTH = 2
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  phaseStb_t                           stb,
  input  logic [PAT_DEPTH-1:0]                patHi,
  input  logic [PAT_DEPTH-1:0]                patLo,
  output logic [NUM_CHAN-1:0][PAT_DEPTH-1:0]  patState,
  output logic                                phaseHiN,
  output logic                                phaseLoN
);

  logic [NUM_CHAN-1:0][PAT_DEPTH-1:0] patIn;
  logic [NUM_CHAN-1:0]                pinN;

  assign patIn[CH_HIGH] = patHi;
  assign patIn[CH_LOW]  = patLo;

  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
    logic [PAT_DEPTH-1:0] slots;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slots <= '1;
      end else if (stb.takeLoad) begin
        slots <= patIn[ch];
      end else if (stb.takeShift) begin
        slots <= {slots[0], slots[PAT_DEPTH-1:1]};
      end
    end

    assign patState[ch] = slots;

    cphase_gate u_gate (
      .clk      (clk),
      .rstN     (rstN),
      .armed    (stb.armed),
      .headBit  (slots[0]),
      .deadBusy (stb.deadBusy),
      .pinN     (pinN[ch])
    );
  end

  assign phaseHiN = pinN[CH_HIGH];
  assign phaseLoN = pinN[CH_LOW];

endmodule

// File: rtl/cphase_out.sv
module cphase_out
  import cphase_out_pkg::*;
#(
  parameter int DEAD_W    = 8,
  parameter int PAT_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PAT_DEPTH-1:0] patHi,
  input  logic [PAT_DEPTH-1:0] patLo,
  input  logic                 loadStb,
  input  logic                 pulseEndStb,
  input  logic [DEAD_W-1:0]    deadCount,
  input  logic                 triMode,
  output logic                 phaseHiN,
  output logic                 phaseLoN
);

  phaseStb_t                          stb;
  logic [NUM_CHAN-1:0][PAT_DEPTH-1:0] patState;

  cphase_ctrl #(.DEAD_W(DEAD_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .loadStb     (loadStb),
    .pulseEndStb (pulseEndStb),
    .triMode     (triMode),
    .deadCount   (deadCount),
    .stb         (stb)
  );

  cphase_dpath #(.PAT_DEPTH(PAT_DEPTH)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .patHi    (patHi),
    .patLo    (patLo),
    .patState (patState),
    .phaseHiN (phaseHiN),
    .phaseLoN (phaseLoN)
  );

endmodule

// File: rtl/cphase_chk.sv
module cphase_chk
  import cphase_out_pkg::*;
#(
  parameter int DEAD_W    = 8,
  parameter int PAT_DEPTH = 2
) (
  input logic                                clk,
  input logic                                rstN,
  input logic [PAT_DEPTH-1:0]                patHi,
  input logic [PAT_DEPTH-1:0]                patLo,
  input logic                                loadStb,
  input logic                                pulseEndStb,
  input logic [DEAD_W-1:0]                   deadCount,
  input logic                                triMode,
  input logic                                phaseHiN,
  input logic                                phaseLoN,
  input phaseStb_t                           stb,
  input logic [NUM_CHAN-1:0][PAT_DEPTH-1:0]  patState
);

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !stb.armed |-> (phaseHiN && phaseLoN)); // R1

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && !triMode) |=> (patState[CH_HIGH] == $past(patHi) && patState[CH_LOW] == $past(patLo))); // R2

  AST_ROTATE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (pulseEndStb && !(loadStb && !triMode)) |=>
      patState[CH_HIGH] == {$past(patState[CH_HIGH][0]), $past(patState[CH_HIGH][PAT_DEPTH-1:1])}); // R3

  AST_RISE_PROMPT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phaseHiN) |-> $past(patState[CH_HIGH][0])); // R4

  AST_RISE_PROMPT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phaseLoN) |-> $past(patState[CH_LOW][0])); // R4

  AST_FALL_WAITS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phaseHiN) |-> !$past(stb.deadBusy)); // R5

  AST_FALL_WAITS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phaseLoN) |-> !$past(stb.deadBusy)); // R5

  AST_DEAD_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (pulseEndStb && !(loadStb && !triMode) && deadCount != '0) |=> stb.deadBusy); // R6

  AST_TRI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (triMode && !pulseEndStb) |=> $stable(patState)); // R7

  AST_LOAD_CLEARS_DEAD: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && !triMode) |=> !stb.deadBusy); // R8

endmodule

bind cphase_out cphase_chk #(.DEAD_W(DEAD_W), .PAT_DEPTH(PAT_DEPTH)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .patHi       (patHi),
  .patLo       (patLo),
  .loadStb     (loadStb),
  .pulseEndStb (pulseEndStb),
  .deadCount   (deadCount),
  .triMode     (triMode),
  .phaseHiN    (phaseHiN),
  .phaseLoN    (phaseLoN),
  .stb         (stb),
  .patState    (patState)
);

// File: tb/tb_cphase_out.sv
module tb_cphase_out;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NROWS      = 28;

  // Row layout: {ld, sh, tri, patHi[1:0], patLo[1:0], dead[7:0], expHi, expLo}
  localparam logic [16:0] VEC [NROWS] = '{
    {1'b1,1'b0,1'b0,2'b01,2'b10,8'd3,1'b1,1'b1},
    {1'b0,1'b0,1'b0,2'b00,2'b00,8'd3,1'b1,1'b0},
    {1'b0,1'b1,1'b0,2'b00,2'b00,8'd3,1'b1,1'b0},
    {1'b0,1'b0,1'b0,2'b00,2'b00,8'd3,1'b1,1'b1},
    {1'b0,1'b0,1'b0,2'b00,2'b00,8'd3,1'b1,1'b1},
    {1'b0,1'b0,1'b0,2'b00,2'b00,8'd3,1'b1,1'b1},
    {1'b0,1'b0,1'b0,2'b00,2'b00,8'd3,1'b0,1'b1},
    {1'b0,1'b1,1'b0,2'b00,2'b00,8'd3,1'b0,1'b1},
    {1'b0,1'b0,1'b0,2'b00,2'b00,8'd3,1'b1,1'b1},
    {1'b0,1'b0,1'b0,2'b00,2'b00,8'd3,1'b1,1'b1},
    {1'b0,1'b0,1'b0,2'b00,2'b00,8'd3,1'b1,1'b1},
    {1'b0,1'b0,1'b0,2'b00,2'b00,8'd3,1'b1,1'b0},
    {1'b0,1'b1,1'b0,2'b00,2'b00,8'd2,1'b1,1'b0},
    {1'b0,1'b0,1'b0,2'b00,2'b00,8'd2,1'b1,1'b1},
    {1'b0,1'b1,1'b0,2'b00,2'b00,8'd2,1'b1,1'b1},
    {1'b0,1'b0,1'b0,2'b00,2'b00,8'd2,1'b1,1'b1},
    {1'b0,1'b0,1'b0,2'b00,2'b00,8'd2,1'b1,1'b1},
    {1'b0,1'b0,1'b0,2'b00,2'b00,8'd2,1'b1,1'b0},
    {1'b1,1'b0,1'b1,2'b00,2'b00,8'd0,1'b1,1'b0},
    {1'b0,1'b1,1'b1,2'b00,2'b00,8'd0,1'b1,1'b0},
    {1'b0,1'b0,1'b1,2'b00,2'b00,8'd0,1'b0,1'b1},
    {1'b1,1'b1,1'b0,2'b10,2'b01,8'd0,1'b0,1'b1},
    {1'b0,1'b0,1'b0,2'b00,2'b00,8'd0,1'b0,1'b1},
    {1'b0,1'b1,1'b0,2'b00,2'b00,8'd4,1'b0,1'b1},
    {1'b1,1'b0,1'b0,2'b10,2'b01,8'd4,1'b1,1'b1},
    {1'b0,1'b0,1'b0,2'b00,2'b00,8'd4,1'b0,1'b1},
    {1'b0,1'b1,1'b0,2'b00,2'b00,8'd0,1'b0,1'b1},
    {1'b0,1'b0,1'b0,2'b00,2'b00,8'd0,1'b1,1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] patHi = '0;
  logic [1:0] patLo = '0;
  logic       loadStb = 1'b0;
  logic       pulseEndStb = 1'b0;
  logic [7:0] deadCount = '0;
  logic       triMode = 1'b0;
  logic       phaseHiN;
  logic       phaseLoN;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  cphase_out dut (
    .clk         (clk),
    .rstN        (rstN),
    .patHi       (patHi),
    .patLo       (patLo),
    .loadStb     (loadStb),
    .pulseEndStb (pulseEndStb),
    .deadCount   (deadCount),
    .triMode     (triMode),
    .phaseHiN    (phaseHiN),
    .phaseLoN    (phaseLoN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic checkPins(input string req, input logic expHi, input logic expLo);
    checks++;
    if (phaseHiN !== expHi || phaseLoN !== expLo) begin
      failures++;
      $display("FAIL %s: pins hi=%b lo=%b, expected hi=%b lo=%b", req, phaseHiN, phaseLoN, expHi, expLo);
    end
  endtask

  function automatic string rowTag(input int k);
    case (k)
      1:       return "R2";
      6, 27:   return "R5";
      8:       return "R4";
      17:      return "R6";
      20:      return "R7";
      22, 25:  return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic idleInputs();
    loadStb = 1'b0; pulseEndStb = 1'b0; triMode = 1'b0;
    patHi = '0; patLo = '0; deadCount = '0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idleInputs();
    repeat (3) @(negedge clk);
    checkPins("R1 reset state", 1'b1, 1'b1);
    rstN = 1'b1;
    @(negedge clk);
    checkPins("R1 after reset release", 1'b1, 1'b1);

    // R1: a rotation with no accepted preload leaves the pins off.
    pulseEndStb = 1'b1; deadCount = 8'd0;
    @(negedge clk);
    pulseEndStb = 1'b0;
    repeat (2) @(negedge clk);
    checkPins("R1 rotate before preload", 1'b1, 1'b1);

    // R7 / R1: a preload in triangle mode is refused, so the pins stay off.
    triMode = 1'b1; loadStb = 1'b1; patHi = 2'b00; patLo = 2'b00;
    @(negedge clk);
    loadStb = 1'b0;
    repeat (3) @(negedge clk);
    checkPins("R7 triangle preload refused", 1'b1, 1'b1);
    idleInputs();

    // Vector table: inputs applied at a falling edge, pins sampled at the next falling edge.
    for (int k = 0; k < NROWS; k++) begin
      loadStb     = VEC[k][16];
      pulseEndStb = VEC[k][15];
      triMode     = VEC[k][14];
      patHi       = VEC[k][13:12];
      patLo       = VEC[k][11:10];
      deadCount   = VEC[k][9:2];
      @(negedge clk);
      checkPins($sformatf("%s row %0d", rowTag(k), k), VEC[k][1], VEC[k][0]);
      checks++;
      if (phaseHiN === 1'b0 && phaseLoN === 1'b0) begin
        failures++;
        $display("FAIL R9 row %0d: both pins low hi=%b lo=%b, expected not both 0", k, phaseHiN, phaseLoN);
      end
    end
    idleInputs();

    // R5: a long dead time with an exact fall time; preload hi=01 lo=10 puts the pins at hi=1, lo=0.
    loadStb = 1'b1; patHi = 2'b01; patLo = 2'b10;
    @(negedge clk);
    loadStb = 1'b0;
    @(negedge clk);
    checkPins("R2 second preload", 1'b1, 1'b0);
    pulseEndStb = 1'b1; deadCount = 8'd20;
    @(negedge clk);
    pulseEndStb = 1'b0;
    repeat (20) @(negedge clk);
    checkPins("R5 still held at deadCount", 1'b1, 1'b1);
    @(negedge clk);
    checkPins("R5 falls at deadCount+1", 1'b0, 1'b1);

    // R1: a reset in mid-run returns both pins to the off level.
    rstN = 1'b0;
    @(negedge clk);
    checkPins("R1 mid-run reset", 1'b1, 1'b1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkPins("R1 idle after reset", 1'b1, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule